// File: doc/BRIEF.md
# Session Receive Read Path

This block sits between the per-session receive storage of a network stack and the application that consumes the received bytes. When bytes arrive for a session, or when a session is torn down, the block raises a notification. The notification gives the session, the number of new bytes, the peer address and port, and a flag that marks a close. The application then pulls the data. It names a session and a byte count on the read-request stream. The block answers with one metadata word carrying the session ID, followed by a packet of data beats. Each beat carries a per-byte keep mask, and the final beat carries a last marker.

Real stream reassembly is not modelled. A small store keeps a byte count and a read offset for each session. The payload is produced from a fixed pattern, so any consumer can predict the content of every byte. Only one read is in progress at a time. The application sees that it may issue the next request when the request-ready signal rises again.

Top module: `srr_read_path`

## Requirements
- R1: A data event (`ev_valid` with `ev_close` low) in the cycle before a rising edge makes `ntf_valid` high for the one cycle after that edge. `ntf_closed` is 0 and session, length, address and port echo the event.
- R2: A close event (`ev_valid` with `ev_close` high) gives a one-cycle notification after the edge, with `ntf_closed` 1 and `ntf_len` 0. It leaves the session's byte count unchanged.
- R3: A session's byte count grows by the length of each of its data events. An accepted request is granted min(`req_len`, count seen at the accepting edge), and the count then drops by the grant. An event and an accept at the same edge both take effect, and the grant does not include that event.
- R4: After a request is accepted, `meta_valid` is high from the next cycle, with `meta_sess` equal to the requested session, until `meta_ready` is seen. No data beat is valid while the metadata is pending. The first beat is valid in the cycle after the metadata handshake.
- R5: Each beat carries `DW` bytes, lane k in bits [8k+7:8k]. Valid byte k holds (16*(session mod 16) + offset + k) mod 256. Offset is the number of bytes already delivered from that session since reset.
- R6: `out_last` is set only on the beat that completes the grant. On that beat `out_keep` bit k is 1 exactly for k below the remaining byte count; every earlier beat has all keep bits set. Lanes whose keep bit is 0 carry zero.
- R7: A grant of zero bytes (an empty session or a zero length) produces the metadata word and no data beat.
- R8: `req_ready` is high only when no read is in progress, and a request presented while it is low has no effect on counts or outputs.
- R9: While `meta_valid` or `out_valid` is high and its ready is low, the valid and its payload stay unchanged in the next cycle.
- R10: After reset, no valid output is high, `req_ready` is 1, and every session's byte count and offset are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Receive-side event strobe |
| ev_close | input | 1 | Event is a session close |
| ev_sess | input | 16 | Event session ID |
| ev_len | input | 16 | Bytes newly arrived |
| ev_ip | input | 32 | Peer IP address of the event |
| ev_port | input | 16 | Destination port of the event |
| ntf_valid | output | 1 | Notification strobe |
| ntf_sess | output | 16 | Notification session ID |
| ntf_len | output | 16 | Notified byte count |
| ntf_ip | output | 32 | Notified peer IP address |
| ntf_port | output | 16 | Notified destination port |
| ntf_closed | output | 1 | Notification marks a close |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request accepted when high |
| req_sess | input | 16 | Requested session ID |
| req_len | input | 16 | Requested byte count |
| meta_valid | output | 1 | Response metadata valid |
| meta_ready | input | 1 | Consumer takes metadata |
| meta_sess | output | 16 | Session ID of the response |
| out_valid | output | 1 | Data beat valid |
| out_ready | input | 1 | Consumer takes data beat |
| out_data | output | 8*DW | Beat payload |
| out_keep | output | DW | One bit per valid byte |
| out_last | output | 1 | Final beat of the response |

## Verification
A notification is due in the cycle after the edge that samples its event. The metadata word is due in the cycle after the accepting edge, and each data beat in the cycle after the preceding handshake. The bench has a behavioural model that advances at each rising edge from the same inputs. At every falling edge it compares the notification, request-ready, metadata and data outputs with the model. The stimulus is random: events, requests and both ready signals are varied cycle by cycle, so backpressure, clamping, zero grants, requests made while busy, and events that coincide with an accept all occur.

// File: rtl/srr_pkg.sv
package srr_pkg;
    localparam int SID_W = 16;
    localparam int LEN_W = 16;

    typedef struct packed {
        logic             valid;
        logic             closed;
        logic [SID_W-1:0] sess;
        logic [LEN_W-1:0] len;
        logic [31:0]      ip;
        logic [15:0]      port;
    } ntf_t;

    typedef struct packed {
        logic             busy;
        logic             meta_pend;
        logic [SID_W-1:0] sess;
        logic [LEN_W-1:0] rem;
        logic [LEN_W-1:0] off;
        ntf_t             ntf;
    } rd_state_t;
endpackage

// File: rtl/srr_count_store.sv
module srr_count_store #(
    parameter int NUM_SESS = 4,
    localparam int IDX_W = (NUM_SESS > 1) ? $clog2(NUM_SESS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             add_en,
    input  logic [IDX_W-1:0] add_idx,
    input  logic [15:0]      add_len,
    input  logic             take_en,
    input  logic [IDX_W-1:0] take_idx,
    input  logic [15:0]      take_len,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [15:0]      rd_cnt,
    output logic [15:0]      rd_off
);
    logic [15:0] cnt_q [NUM_SESS];
    logic [15:0] cnt_d [NUM_SESS];
    logic [15:0] off_q [NUM_SESS];
    logic [15:0] off_d [NUM_SESS];

    always_comb begin
        cnt_d = cnt_q;
        off_d = off_q;
        if (add_en) begin
            cnt_d[add_idx] = cnt_d[add_idx] + add_len;
        end
        if (take_en) begin
            cnt_d[take_idx] = cnt_d[take_idx] - take_len;
            off_d[take_idx] = off_d[take_idx] + take_len;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SESS; i++) begin
                cnt_q[i] <= '0;
                off_q[i] <= '0;
            end
        end else begin
            cnt_q <= cnt_d;
            off_q <= off_d;
        end
    end

    assign rd_cnt = cnt_q[rd_idx];
    assign rd_off = off_q[rd_idx];

    AST_TAKE_WITHIN_COUNT: assert property (@(posedge clk) disable iff (rst)
        take_en |-> take_len <= cnt_q[take_idx]); // R3
endmodule

// File: rtl/srr_beat_gen.sv
module srr_beat_gen #(
    parameter int DW = 8,
    localparam int DATA_W = DW * 8
) (
    input  logic [3:0]        sess_lo,
    input  logic [7:0]        off_lo,
    input  logic [15:0]       rem,
    output logic [DATA_W-1:0] data,
    output logic [DW-1:0]     keep,
    output logic              last
);
    localparam logic [15:0] DW_LEN = 16'(DW);

    logic [7:0] base;
    assign base = {sess_lo, 4'b0000} + off_lo;
    assign last = (rem <= DW_LEN);

    for (genvar k = 0; k < DW; k++) begin : g_lane
        logic lane_on;
        assign lane_on = (16'(k) < rem);
        assign keep[k] = lane_on;
        assign data[8*k +: 8] = lane_on ? (base + 8'(k)) : 8'h00;
    end
endmodule

// File: rtl/srr_read_path.sv
module srr_read_path
    import srr_pkg::*;
#(
    parameter int NUM_SESS = 4,
    parameter int DW = 8,
    localparam int IDX_W = (NUM_SESS > 1) ? $clog2(NUM_SESS) : 1,
    localparam int DATA_W = DW * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic              ev_close,
    input  logic [15:0]       ev_sess,
    input  logic [15:0]       ev_len,
    input  logic [31:0]       ev_ip,
    input  logic [15:0]       ev_port,
    output logic              ntf_valid,
    output logic [15:0]       ntf_sess,
    output logic [15:0]       ntf_len,
    output logic [31:0]       ntf_ip,
    output logic [15:0]       ntf_port,
    output logic              ntf_closed,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [15:0]       req_sess,
    input  logic [15:0]       req_len,
    output logic              meta_valid,
    input  logic              meta_ready,
    output logic [15:0]       meta_sess,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [DW-1:0]     out_keep,
    output logic              out_last
);
    localparam logic [15:0] DW_LEN = 16'(DW);

    rd_state_t st_q, st_d;
    logic        accept;
    logic [15:0] avail, have_off, grant, beat_len;

    assign accept = req_valid && !st_q.busy;
    assign grant  = (req_len < avail) ? req_len : avail;
    assign beat_len = (st_q.rem > DW_LEN) ? DW_LEN : st_q.rem;

    srr_count_store #(.NUM_SESS(NUM_SESS)) u_store (
        .clk      (clk),
        .rst      (rst),
        .add_en   (ev_valid && !ev_close),
        .add_idx  (ev_sess[IDX_W-1:0]),
        .add_len  (ev_len),
        .take_en  (accept),
        .take_idx (req_sess[IDX_W-1:0]),
        .take_len (grant),
        .rd_idx   (req_sess[IDX_W-1:0]),
        .rd_cnt   (avail),
        .rd_off   (have_off)
    );

    always_comb begin
        st_d = st_q;
        st_d.ntf.valid  = ev_valid;
        st_d.ntf.closed = ev_close;
        st_d.ntf.sess   = ev_sess;
        st_d.ntf.len    = ev_close ? 16'd0 : ev_len;
        st_d.ntf.ip     = ev_ip;
        st_d.ntf.port   = ev_port;
        if (st_q.busy && st_q.meta_pend) begin
            if (meta_ready) begin
                st_d.meta_pend = 1'b0;
                if (st_q.rem == 16'd0) st_d.busy = 1'b0;
            end
        end else if (st_q.busy) begin
            if (out_ready) begin
                st_d.rem = st_q.rem - beat_len;
                st_d.off = st_q.off + beat_len;
                if (st_q.rem <= DW_LEN) st_d.busy = 1'b0;
            end
        end else if (accept) begin
            st_d.busy      = 1'b1;
            st_d.meta_pend = 1'b1;
            st_d.sess      = req_sess;
            st_d.rem       = grant;
            st_d.off       = have_off;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    srr_beat_gen #(.DW(DW)) u_beat (
        .sess_lo (st_q.sess[3:0]),
        .off_lo  (st_q.off[7:0]),
        .rem     (st_q.rem),
        .data    (out_data),
        .keep    (out_keep),
        .last    (out_last)
    );

    assign req_ready  = !st_q.busy;
    assign meta_valid = st_q.busy && st_q.meta_pend;
    assign meta_sess  = st_q.sess;
    assign out_valid  = st_q.busy && !st_q.meta_pend;
    assign ntf_valid  = st_q.ntf.valid;
    assign ntf_closed = st_q.ntf.closed;
    assign ntf_sess   = st_q.ntf.sess;
    assign ntf_len    = st_q.ntf.len;
    assign ntf_ip     = st_q.ntf.ip;
    assign ntf_port   = st_q.ntf.port;

    AST_META_FIRST: assert property (@(posedge clk) disable iff (rst)
        !(meta_valid && out_valid)); // R4
    AST_META_HOLD: assert property (@(posedge clk) disable iff (rst)
        meta_valid && !meta_ready |=> meta_valid && $stable(meta_sess)); // R9
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_keep) && $stable(out_last)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !meta_valid && !out_valid); // R8
    AST_CLOSE_ZERO: assert property (@(posedge clk) disable iff (rst)
        ntf_valid && ntf_closed |-> ntf_len == 16'd0); // R2
    AST_FULL_KEEP: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_last |-> &out_keep); // R6
endmodule

// File: tb/srr_read_path_bench.sv
module srr_read_path_bench;
    localparam int NS = 4;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic ev_valid = 0, ev_close = 0;
    logic [15:0] ev_sess = 0, ev_len = 0, ev_port = 0;
    logic [31:0] ev_ip = 0;
    logic req_valid = 0, meta_ready = 0, out_ready = 0;
    logic [15:0] req_sess = 0, req_len = 0;
    logic ntf_valid, ntf_closed, req_ready, meta_valid, out_valid, out_last;
    logic [15:0] ntf_sess, ntf_len, ntf_port, meta_sess;
    logic [31:0] ntf_ip;
    logic [DW*8-1:0] out_data;
    logic [DW-1:0] out_keep;

    srr_read_path #(.NUM_SESS(NS), .DW(DW)) u_srr_read_path (
        .clk(clk), .rst(rst),
        .ev_valid(ev_valid), .ev_close(ev_close), .ev_sess(ev_sess), .ev_len(ev_len),
        .ev_ip(ev_ip), .ev_port(ev_port),
        .ntf_valid(ntf_valid), .ntf_sess(ntf_sess), .ntf_len(ntf_len), .ntf_ip(ntf_ip),
        .ntf_port(ntf_port), .ntf_closed(ntf_closed),
        .req_valid(req_valid), .req_ready(req_ready), .req_sess(req_sess), .req_len(req_len),
        .meta_valid(meta_valid), .meta_ready(meta_ready), .meta_sess(meta_sess),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_keep(out_keep), .out_last(out_last)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // behavioural reference
    int cnt [NS];
    int offs [NS];
    bit m_busy = 0, m_meta = 0;
    int m_sess = 0, m_rem = 0, m_off = 0;
    bit e_nv = 0, e_nc = 0;
    int e_ns = 0, e_nl = 0, e_np = 0;
    logic [31:0] e_nip = 0;
    int zero_grants = 0, clamps = 0;

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NS; i++) begin cnt[i] = 0; offs[i] = 0; end
            m_busy = 0; m_meta = 0; m_rem = 0; m_off = 0; m_sess = 0; e_nv = 0;
        end else begin
            int g;
            int s;
            s = req_sess % NS;
            g = (req_len < cnt[s]) ? req_len : cnt[s];
            e_nv = ev_valid; e_nc = ev_close; e_ns = ev_sess;
            e_nl = ev_close ? 0 : ev_len; e_nip = ev_ip; e_np = ev_port;
            if (m_busy && m_meta) begin
                if (meta_ready) begin m_meta = 0; if (m_rem == 0) m_busy = 0; end
            end else if (m_busy) begin
                if (out_ready) begin
                    int n;
                    n = (m_rem > DW) ? DW : m_rem;
                    m_rem -= n; m_off += n;
                    if (m_rem == 0) m_busy = 0;
                end
            end else if (req_valid) begin
                m_busy = 1; m_meta = 1; m_sess = req_sess; m_rem = g; m_off = offs[s];
                cnt[s] -= g; offs[s] += g;
                if (g == 0) zero_grants++;
                if (g < req_len) clamps++;
            end
            if (ev_valid && !ev_close) cnt[ev_sess % NS] += ev_len;
        end
    end

    logic [DW*8-1:0] prev_data;
    logic [DW-1:0] prev_keep;
    bit prev_stall = 0, prev_mstall = 0;
    logic [15:0] prev_msess;

    task automatic compare_all();
        chk(ntf_valid == e_nv, e_nc ? "R2" : "R1", "ntf_valid", ntf_valid, e_nv);
        if (e_nv) begin
            chk(ntf_closed == e_nc && ntf_len == 16'(e_nl), e_nc ? "R2" : "R1", "ntf_len", ntf_len, e_nl);
            chk(ntf_sess == 16'(e_ns) && ntf_ip == e_nip && ntf_port == 16'(e_np), "R1", "ntf_sess", ntf_sess, e_ns);
        end
        chk(req_ready == !m_busy, "R8", "req_ready", req_ready, !m_busy);
        chk(meta_valid == (m_busy && m_meta), "R4", "meta_valid", meta_valid, m_busy && m_meta);
        if (m_busy && m_meta) chk(meta_sess == 16'(m_sess), "R4", "meta_sess", meta_sess, m_sess);
        chk(out_valid == (m_busy && !m_meta), "R7", "out_valid", out_valid, m_busy && !m_meta);
        if (m_busy && !m_meta) begin
            logic [DW*8-1:0] ed;
            logic [DW-1:0] ek;
            for (int k = 0; k < DW; k++) begin
                ek[k] = (k < m_rem);
                ed[8*k +: 8] = ek[k] ? 8'((m_sess % 16) * 16 + m_off + k) : 8'h00;
            end
            chk(out_data == ed, "R3 R5", "out_data", out_data, ed);
            chk(out_keep == ek, "R6", "out_keep", out_keep, ek);
            chk(out_last == (m_rem <= DW), "R6", "out_last", out_last, m_rem <= DW);
        end
        if (prev_stall) chk(out_valid && out_data == prev_data && out_keep == prev_keep, "R9", "held data", out_data, prev_data);
        if (prev_mstall) chk(meta_valid && meta_sess == prev_msess, "R9", "held meta", meta_sess, prev_msess);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk(!ntf_valid && !meta_valid && !out_valid, "R10", "valids in reset", {ntf_valid, meta_valid, out_valid}, 0);
        chk(req_ready == 1'b1, "R10", "req_ready in reset", req_ready, 1);
        rst = 0;
        for (int cyc = 0; cyc < 6000; cyc++) begin
            @(negedge clk);
            compare_all();
            prev_stall  = out_valid && !out_ready;
            prev_mstall = meta_valid && !meta_ready;
            prev_data = out_data; prev_keep = out_keep; prev_msess = meta_sess;
            ev_valid = ($urandom_range(0, 99) < 20);
            ev_close = ($urandom_range(0, 4) == 0);
            ev_sess  = 16'($urandom_range(0, NS - 1));
            ev_len   = 16'($urandom_range(0, 40));
            ev_ip    = $urandom;
            ev_port  = 16'($urandom);
            req_valid = ($urandom_range(0, 99) < 30);
            req_sess  = 16'($urandom_range(0, NS - 1));
            req_len   = 16'($urandom_range(0, 50));
            meta_ready = ($urandom_range(0, 99) < 70);
            out_ready  = ($urandom_range(0, 99) < 70);
            prev_stall  = prev_stall && 1'b0;
            prev_mstall = prev_mstall && 1'b0;
            if (out_valid && !out_ready) prev_stall = 1;
            if (meta_valid && !meta_ready) prev_mstall = 1;
        end
        // R3 clamping and R7 zero grants must both have occurred
        chk(clamps > 0, "R3", "clamped requests seen", clamps, 1);
        chk(zero_grants > 0, "R7", "zero grants seen", zero_grants, 1);
        done = 1;
        summary();
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
        end
    end
endmodule